// File: doc/BRIEF.md
# YUV to RGB Color Converter

This block converts a stream of 8-bit luma/chroma pixels into 8-bit red, green and blue. One pixel can enter on every clock cycle. Each output component is formed from a programmable row of four coefficients: three signed weights applied to Y, U and V, and one signed additive constant. The weighted sum is then rounded to an integer and saturated into the 8-bit range. Reset loads a limited-range-to-full-range conversion. With this default, Y codes 16..235 and chroma codes 16..240 map onto RGB 0..255.

Software writes new coefficients through a twelve-entry write port. Writes land in a holding copy, and the datapath keeps using its working copy until a frame-start pulse. This lets a whole matrix be changed between frames without any pixel seeing a half-updated set. A per-pixel bypass flag sends an already-RGB pixel through untouched. A bypassed pixel leaves with the same latency as a converted one, so bypassed and converted pixels can be mixed freely in one stream.

Top module: `yuv_rgb_csc`

## Requirements
- R1: `out_valid` rises exactly three clock edges after the edge that samples `in_valid` high, and the pixels leave in the order they entered.
- R2: Each output is computed as follows. Multiply each weight by its component, with the component taken as unsigned. Add the three products. Add the constant shifted left by 6. Add 512. Shift the total arithmetically right by 10, so the integer part is rounded toward minus infinity.
- R3: A result below 0 is output as 0.
- R4: A result above 255 is output as 255.
- R5: Coefficient address 4*row+term selects the entry. Row 0 drives `out_g`, row 1 drives `out_r` and row 2 drives `out_b`. Term 0 weights Y, term 1 weights U, term 2 weights V, and term 3 is the constant. A weight is bits [12:0] of `coef_data`, signed with 10 fractional bits. The constant is all 14 bits of `coef_data`, signed with 4 fractional bits.
- R6: After reset the twelve entries, in address order, hold 0x04a7, 0x1e6f, 0x1cbf, 0x0877, 0x04a7, 0x0000, 0x0662, 0x3211, 0x04a7, 0x0812, 0x0000, 0x2eb1.
- R7: A pixel presented with `bypass` high leaves with `out_r`=Y, `out_g`=U and `out_b`=V after the same three-cycle latency. Bypassed and converted pixels may alternate on consecutive cycles without a gap.
- R8: A write with `coef_we` high changes only the holding copy. The working copy takes the holding copy at an edge where `frame_start` is high; a write in that same cycle joins at the next pulse. A pixel sampled at or before that edge uses the old set.
- R9: A write to address 12 to 15 changes no coefficient.
- R10: While reset is asserted, and on the first edge after it, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_y | input | 8 | Luma (or first component in bypass) |
| in_u | input | 8 | Blue-difference chroma (or second component) |
| in_v | input | 8 | Red-difference chroma (or third component) |
| bypass | input | 1 | Pass this pixel through unconverted |
| frame_start | input | 1 | Copy holding coefficients into the working set |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Coefficient index, 4*row+term |
| coef_data | input | 14 | Coefficient value |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
The hardest case to reach is a coefficient change that overlaps pixels still inside the pipe. Pixels entering before the frame-start pulse must finish with the old matrix, and those after it must use the new one. The stimulus streams pixels, writes a complete permuted-identity matrix while those pixels are still in flight, and sends more pixels before the pulse. It then pulses frame start and immediately streams again, so the old-to-new boundary falls inside one run of outputs. Rounding ties are reached by loading constants with fractional parts of exactly one half and just below one half.

// File: rtl/csc_pkg.sv
package csc_pkg;
   localparam int N_ROWS  = 3;
   localparam int N_TERMS = 4;
   localparam int N_COEF  = N_ROWS * N_TERMS;
   localparam int ADDR_W  = $clog2(N_COEF + 4);

   // Output row order inside the coefficient set.
   typedef enum int {ROW_G = 0, ROW_R = 1, ROW_B = 2} row_e;

   // Reset matrix as integers: weights at 10 fractional bits,
   // constants at 4 fractional bits.
   function automatic int dflt_coef(int idx);
      case (idx)
         0:       return 1191;
         1:       return -401;
         2:       return -833;
         3:       return 2167;
         4:       return 1191;
         5:       return 0;
         6:       return 1634;
         7:       return -3567;
         8:       return 1191;
         9:       return 2066;
         10:      return 0;
         11:      return -4431;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/csc_delay.sv
module csc_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (DEPTH < 1) begin : g_bad_depth
      $fatal(1, "csc_delay: DEPTH must be at least 1");
   end

   logic [W-1:0] stage [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage[k] <= '0;
         else if (k == 0)
            stage[k] <= d;
         else
            stage[k] <= stage[(k == 0) ? 0 : k-1];
      end
   end

   assign q = stage[DEPTH-1];
endmodule

// File: rtl/csc_channel.sv
module csc_channel #(
   parameter int PIX_W    = 8,
   parameter int MUL_W    = 13,
   parameter int MUL_FRAC = 10,
   parameter int OFS_W    = 14,
   parameter int OFS_FRAC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] c0,
   input  logic [PIX_W-1:0] c1,
   input  logic [PIX_W-1:0] c2,
   input  logic [MUL_W-1:0] k0,
   input  logic [MUL_W-1:0] k1,
   input  logic [MUL_W-1:0] k2,
   input  logic [OFS_W-1:0] kc,
   output logic [PIX_W-1:0] res
);
   localparam int PROD_W = MUL_W + PIX_W + 1;
   localparam int SHIFT  = MUL_FRAC - OFS_FRAC;
   localparam int OFS_X  = OFS_W + SHIFT;
   localparam int SUM_W  = ((PROD_W + 2) > OFS_X ? (PROD_W + 2) : OFS_X) + 1;
   localparam logic signed [SUM_W-1:0] HALF  = SUM_W'(1) <<< (MUL_FRAC - 1);
   localparam logic signed [SUM_W-1:0] TOP_V = SUM_W'((1 << PIX_W) - 1);

   if (SHIFT < 0) begin : g_bad_frac
      $fatal(1, "csc_channel: constant cannot be finer than the weights");
   end

   // Stage 1: products and aligned constant.
   logic signed [PROD_W-1:0] p0, p1, p2;
   logic signed [SUM_W-1:0]  cst;

   logic signed [MUL_W-1:0] k0s, k1s, k2s;
   logic signed [OFS_W-1:0] kcs;
   logic signed [PIX_W:0]   x0, x1, x2;

   always_comb begin
      k0s = k0;
      k1s = k1;
      k2s = k2;
      kcs = kc;
      x0  = {1'b0, c0};
      x1  = {1'b0, c1};
      x2  = {1'b0, c2};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p0  <= '0;
         p1  <= '0;
         p2  <= '0;
         cst <= '0;
      end else begin
         p0  <= PROD_W'(k0s) * PROD_W'(x0);
         p1  <= PROD_W'(k1s) * PROD_W'(x1);
         p2  <= PROD_W'(k2s) * PROD_W'(x2);
         cst <= SUM_W'(kcs) <<< SHIFT;
      end
   end

   // Stage 2: accumulate.
   logic signed [SUM_W-1:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else
         acc <= SUM_W'(p0) + SUM_W'(p1) + SUM_W'(p2) + cst;
   end

   // Stage 3: round, scale down, saturate.
   logic signed [SUM_W-1:0] rnd, whole;

   always_comb begin
      rnd   = acc + HALF;
      whole = rnd >>> MUL_FRAC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         res <= '0;
      else if (whole[SUM_W-1])
         res <= '0;
      else if (whole > TOP_V)
         res <= '1;
      else
         res <= whole[PIX_W-1:0];
   end
endmodule

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
   import csc_pkg::*;
#(
   parameter int COEF_W   = 14,
   parameter bit SHADOWED = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [COEF_W-1:0]             wdata,
   input  logic                          commit,
   output logic [N_COEF-1:0][COEF_W-1:0] active
);
   logic hit;
   assign hit = we && (addr < ADDR_W'(N_COEF));

   if (SHADOWED) begin : g_shadow
      logic [N_COEF-1:0][COEF_W-1:0] hold;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < N_COEF; i++)
               hold[i] <= COEF_W'(dflt_coef(i));
         end else if (hit) begin
            hold[addr] <= wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < N_COEF; i++)
               active[i] <= COEF_W'(dflt_coef(i));
         end else if (commit) begin
            active <= hold;
         end
      end
   end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < N_COEF; i++)
               active[i] <= COEF_W'(dflt_coef(i));
         end else if (hit) begin
            active[addr] <= wdata;
         end
      end
   end
endmodule

// File: rtl/yuv_rgb_csc.sv
module yuv_rgb_csc
   import csc_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int MUL_W    = 13,
   parameter int MUL_FRAC = 10,
   parameter int OFS_W    = 14,
   parameter int OFS_FRAC = 4,
   parameter bit SHADOWED = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              in_valid,
   input  logic [PIX_W-1:0]                  in_y,
   input  logic [PIX_W-1:0]                  in_u,
   input  logic [PIX_W-1:0]                  in_v,
   input  logic                              bypass,
   input  logic                              frame_start,
   input  logic                              coef_we,
   input  logic [ADDR_W-1:0]                 coef_addr,
   input  logic [((MUL_W > OFS_W) ? MUL_W : OFS_W)-1:0] coef_data,
   output logic                              out_valid,
   output logic [PIX_W-1:0]                  out_r,
   output logic [PIX_W-1:0]                  out_g,
   output logic [PIX_W-1:0]                  out_b
);
   localparam int COEF_W = (MUL_W > OFS_W) ? MUL_W : OFS_W;
   localparam int LAT    = 3;
   localparam int SIDE_W = 2 + 3 * PIX_W;

   if (MUL_FRAC < OFS_FRAC) begin : g_bad_frac
      $fatal(1, "yuv_rgb_csc: MUL_FRAC must not be below OFS_FRAC");
   end
   if (MUL_W <= MUL_FRAC || MUL_FRAC < 1) begin : g_bad_mul
      $fatal(1, "yuv_rgb_csc: weight format needs integer and fraction bits");
   end
   if (PIX_W < 2) begin : g_bad_pix
      $fatal(1, "yuv_rgb_csc: PIX_W too small");
   end

   logic [N_COEF-1:0][COEF_W-1:0] coefs;

   csc_coef_bank #(
      .COEF_W   (COEF_W),
      .SHADOWED (SHADOWED)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (coef_we),
      .addr   (coef_addr),
      .wdata  (coef_data),
      .commit (frame_start),
      .active (coefs)
   );

   logic [N_ROWS-1:0][PIX_W-1:0] row_res;

   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      csc_channel #(
         .PIX_W    (PIX_W),
         .MUL_W    (MUL_W),
         .MUL_FRAC (MUL_FRAC),
         .OFS_W    (OFS_W),
         .OFS_FRAC (OFS_FRAC)
      ) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .c0    (in_y),
         .c1    (in_u),
         .c2    (in_v),
         .k0    (coefs[r*N_TERMS+0][MUL_W-1:0]),
         .k1    (coefs[r*N_TERMS+1][MUL_W-1:0]),
         .k2    (coefs[r*N_TERMS+2][MUL_W-1:0]),
         .kc    (coefs[r*N_TERMS+3][OFS_W-1:0]),
         .res   (row_res[r])
      );
   end

   // Side path: qualifier, bypass flag and raw components, delayed to match.
   logic [SIDE_W-1:0] side_d, side_q;
   logic              vld_q, byp_q;
   logic [PIX_W-1:0]  y_q, u_q, v_q;

   assign side_d = {in_valid, in_valid & bypass, in_y, in_u, in_v};

   csc_delay #(
      .W     (SIDE_W),
      .DEPTH (LAT)
   ) u_side (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (side_d),
      .q     (side_q)
   );

   assign {vld_q, byp_q, y_q, u_q, v_q} = side_q;

   assign out_valid = vld_q;
   assign out_r     = byp_q ? y_q : row_res[ROW_R];
   assign out_g     = byp_q ? u_q : row_res[ROW_G];
   assign out_b     = byp_q ? v_q : row_res[ROW_B];
endmodule

// File: rtl/csc_chk.sv
module csc_chk #(
   parameter int PIX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [PIX_W-1:0] in_y,
   input logic [PIX_W-1:0] in_u,
   input logic [PIX_W-1:0] in_v,
   input logic             bypass,
   input logic             out_valid,
   input logic [PIX_W-1:0] out_r,
   input logic [PIX_W-1:0] out_g,
   input logic [PIX_W-1:0] out_b
);
   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_rst <= '0;
      else if (since_rst != 2'd3)
         since_rst <= since_rst + 2'd1;
   end

   // R1
   lat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   // R7
   pass_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && out_valid && $past(bypass, 3)) |-> (out_r == $past(in_y, 3)));

   // R7
   pass_g_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && out_valid && $past(bypass, 3)) |-> (out_g == $past(in_u, 3)));

   // R7
   pass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && out_valid && $past(bypass, 3)) |-> (out_b == $past(in_v, 3)));

   // R10
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
endmodule

bind yuv_rgb_csc csc_chk #(.PIX_W(PIX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_y      (in_y),
   .in_u      (in_u),
   .in_v      (in_v),
   .bypass    (bypass),
   .out_valid (out_valid),
   .out_r     (out_r),
   .out_g     (out_g),
   .out_b     (out_b)
);

// File: tb/yuv_rgb_csc_bench.sv
`timescale 1ns/1ps
module yuv_rgb_csc_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_y = '0, in_u = '0, in_v = '0;
   logic       bypass = 1'b0;
   logic       frame_start = 1'b0;
   logic       coef_we = 1'b0;
   logic [3:0] coef_addr = '0;
   logic [13:0] coef_data = '0;
   logic       out_valid;
   logic [7:0] out_r, out_g, out_b;

   always #4 clk = ~clk;

   yuv_rgb_csc u_yuv_rgb_csc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_y(in_y), .in_u(in_u), .in_v(in_v), .bypass(bypass),
      .frame_start(frame_start), .coef_we(coef_we),
      .coef_addr(coef_addr), .coef_data(coef_data),
      .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   typedef struct {
      logic [7:0] r, g, b;
      int         issue;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   int   cyc = 0;
   bit   done = 1'b0;
   int   hold_m [12];
   int   act_m  [12];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int wgt(int c);
      int m = c & 'h1fff;
      if (m >= 4096) m -= 8192;
      return m;
   endfunction

   function automatic int cst(int c);
      int m = c & 'h3fff;
      if (m >= 8192) m -= 16384;
      return m;
   endfunction

   // R2 R3 R4 R5: row result from the bench's working-set copy
   function automatic logic [7:0] row_val(int row, int y, int u, int v);
      longint s;
      longint w;
      s = longint'(wgt(act_m[row*4+0])) * y + longint'(wgt(act_m[row*4+1])) * u
        + longint'(wgt(act_m[row*4+2])) * v + longint'(cst(act_m[row*4+3])) * 64;
      w = (s + 512) >>> 10;
      if (w < 0) return 8'd0;
      if (w > 255) return 8'd255;
      return w[7:0];
   endfunction

   task automatic tick();
      @(negedge clk);
      in_valid = 1'b0; bypass = 1'b0; frame_start = 1'b0; coef_we = 1'b0;
   endtask

   task automatic send(input int y, input int u, input int v, input bit byp, input string tag);
      exp_t e;
      if (byp) begin
         e.r = y[7:0]; e.g = u[7:0]; e.b = v[7:0];
      end else begin
         e.g = row_val(0, y, u, v);
         e.r = row_val(1, y, u, v);
         e.b = row_val(2, y, u, v);
      end
      e.issue = cyc;
      e.tag = tag;
      q.push_back(e);
      in_valid = 1'b1; in_y = y[7:0]; in_u = u[7:0]; in_v = v[7:0]; bypass = byp;
      tick();
   endtask

   task automatic wr(input int a, input int d);
      if (a < 12) hold_m[a] = d & 'h3fff;
      coef_we = 1'b1; coef_addr = a[3:0]; coef_data = d[13:0];
      tick();
   endtask

   task automatic pulse();
      act_m = hold_m;
      frame_start = 1'b1;
      tick();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL [R1] unexpected output r=%0d g=%0d b=%0d, expected none", out_r, out_g, out_b);
         end else begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (out_r !== e.r || out_g !== e.g || out_b !== e.b) begin
               n_bad++;
               $display("FAIL [%s] rgb actual=%0d,%0d,%0d expected=%0d,%0d,%0d",
                        e.tag, out_r, out_g, out_b, e.r, e.g, e.b);
            end
            n_chk++;
            if (cyc - e.issue != 3) begin
               n_bad++;
               $display("FAIL [R1] latency actual=%0d expected=3", cyc - e.issue);
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < 12; i++) begin
         hold_m[i] = csc_pkg::dflt_coef(i) & 'h3fff;
         act_m[i]  = hold_m[i];
      end
      repeat (3) @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) begin
         n_bad++; $display("FAIL [R10] out_valid in reset actual=%b expected=0", out_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) begin
         n_bad++; $display("FAIL [R10] out_valid after reset actual=%b expected=0", out_valid);
      end

      // R6 default matrix, several patterns
      send(16, 128, 128, 0, "R6");
      send(235, 128, 128, 0, "R6");
      send(100, 90, 200, 0, "R6");
      send(81, 90, 240, 0, "R6");
      idle(2);
      send(145, 54, 34, 0, "R6");
      // R3 low clamp, R4 high clamp
      send(0, 0, 255, 0, "R3");
      send(16, 240, 16, 0, "R3");
      send(255, 255, 0, 0, "R4");
      send(255, 0, 255, 0, "R4");
      // R7 bypass alternating back-to-back
      send(3, 77, 250, 1, "R7");
      send(50, 60, 70, 0, "R7");
      send(255, 0, 128, 1, "R7");
      send(9, 8, 7, 1, "R7");
      send(200, 30, 30, 0, "R7");

      // R8 new matrix written while pixels are in flight
      send(120, 40, 220, 0, "R8");
      wr(0, 0); wr(1, 'h400); wr(2, 0); wr(3, 0);
      send(120, 40, 220, 0, "R8");
      wr(4, 0); wr(5, 0); wr(6, 'h400); wr(7, 0);
      wr(8, 'h400); wr(9, 0); wr(10, 0); wr(11, 0);
      send(10, 20, 30, 0, "R8");
      pulse();
      // R5 permuted identity: G=U, R=V, B=Y
      send(10, 20, 30, 0, "R5");
      send(200, 100, 50, 0, "R5");

      // R9 writes above the set are dropped
      wr(12, 'h3fff); wr(13, 'h1234); wr(15, 'h2000);
      pulse();
      send(11, 22, 33, 0, "R9");

      // R2 rounding: tie rounds up, below-half rounds down, negative weight
      wr(8, 'h400); wr(11, 'h3ff8);
      wr(4, 'h400); wr(7, 'h3ff7);
      wr(0, 'h1c00); wr(1, 0); wr(2, 0); wr(3, 'h0ff8);
      pulse();
      send(10, 0, 0, 0, "R2");
      send(100, 5, 5, 0, "R2");
      send(1, 1, 1, 0, "R2");

      // R8 write in the commit cycle waits for the next pulse
      hold_m[1] = 'h400;
      act_m = hold_m;
      act_m[1] = 0;
      coef_we = 1'b1; coef_addr = 4'd1; coef_data = 14'h0400; frame_start = 1'b1;
      tick();
      send(100, 50, 0, 0, "R8");
      pulse();
      send(100, 50, 0, 0, "R8");

      idle(6);
      n_chk++;
      if (q.size() != 0) begin
         n_bad++; $display("FAIL [R1] pending outputs actual=%0d expected=0", q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL [R1] watchdog expired actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule